// File: doc/BRIEF.md
# Supply-Tracking Limiter Threshold Generator

This block turns a measured supply voltage sample into the threshold an audio limiter compares peaks against. Two curves are available, chosen by a mode input. The breakpoint curve holds a programmed ceiling while the supply sits at or above a knee voltage. Below the knee, the threshold falls with the supply at a programmable slope and stops at a programmed floor. The headroom curve scales the supply by a signed percentage, so the threshold can sit a few percent above the rail (fixed clipping) or a few percent below it (clipping avoided).

Voltages, the knee, the ceiling and the floor are unsigned Q8.8 volts. The slope is unsigned Q4.12 V/V. The headroom is a 5-bit two's complement percentage. The result is registered once per accepted sample and held between samples. The register that holds the mode bit should power up with headroom mode selected.

Top module: `lim_thr_top`

## Requirements
- R1: After reset and before the first accepted sample, `thr_o` equals `max_thr_i` and `thr_vld_o` is low.
- R2: One clock edge after a cycle with `sup_vld_i` high, `thr_o` shows the threshold for that cycle's inputs and `thr_vld_o` is high. `thr_vld_o` is low in every cycle that does not follow a strobe.
- R3: Once a sample has been accepted, `thr_o` holds its value while `sup_vld_i` is low, even if every other input changes.
- R4: In breakpoint mode (`dyn_mode_i`=0) with `sup_i` >= `infl_i`, the threshold equals `max_thr_i`.
- R5: In breakpoint mode with `sup_i` < `infl_i`, the candidate threshold is `max_thr_i` − floor(`slope_i`·(`infl_i`−`sup_i`)/4096), with the product kept at full 32-bit width.
- R6: In breakpoint mode, when that reduction is equal to or larger than `max_thr_i`, the candidate is 0 rather than wrapping.
- R7: In breakpoint mode below the knee, the threshold is the larger of the candidate and `min_thr_i`.
- R8: In headroom mode (`dyn_mode_i`=1), h is `hdr_i` read as two's complement (−16..+15). The factor is f = floor(((100−h)·32768+50)/100), and the threshold is floor(`sup_i`·f/32768). A negative h gives a value at or above the supply, and h ≥ 0 gives a value at or below it.
- R9: In headroom mode, a result above 0xFFFF saturates to 0xFFFF.
- R10: In headroom mode, `max_thr_i`, `infl_i`, `slope_i` and `min_thr_i` have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sup_i | input | 16 | Supply sample, Q8.8 volts |
| sup_vld_i | input | 1 | Sample strobe |
| max_thr_i | input | 16 | Ceiling threshold, Q8.8 |
| infl_i | input | 16 | Knee voltage, Q8.8 |
| slope_i | input | 16 | Tracking slope, Q4.12 V/V |
| min_thr_i | input | 16 | Floor threshold, Q8.8 |
| hdr_i | input | 5 | Headroom percent, two's complement |
| dyn_mode_i | input | 1 | 1 selects headroom mode, 0 selects breakpoint mode |
| thr_o | output | 16 | Threshold, Q8.8 |
| thr_vld_o | output | 1 | High for one cycle after each accepted sample |

## Verification
A wrong factor entry or a wrong slope product shows up at `thr_o` one cycle after the strobe. It only appears when the stimulus hits that headroom code or that region of the curve, so the random stimulus sweeps every code and both sides of the knee. A broken hold register shows as `thr_o` drifting in the quiet cycle that follows an update. A missing zero clamp shows as a near-full-scale threshold when the floor is zero and the drop is large.

// File: rtl/lim_thr_pkg.sv
package lim_thr_pkg;
  localparam int V_W    = 16;
  localparam int S_W    = 16;
  localparam int S_FRAC = 12;
  localparam int H_W    = 5;
  localparam int F_FRAC = 15;

  // Q2.15 factor for (100 - h)%, rounded half up
  function automatic int hdr_factor(input int h, input int frac);
    return ((100 - h) * (1 << frac) + 50) / 100;
  endfunction
endpackage

// File: rtl/lim_thr_curve.sv
module lim_thr_curve #(
  parameter int V_W    = 16,
  parameter int S_W    = 16,
  parameter int S_FRAC = 12
) (
  input  logic [V_W-1:0] sup_i,
  input  logic [V_W-1:0] max_i,
  input  logic [V_W-1:0] infl_i,
  input  logic [S_W-1:0] slope_i,
  input  logic [V_W-1:0] min_i,
  output logic [V_W-1:0] thr_o
);
  localparam int P_W = V_W + S_W;
  localparam int D_W = P_W - S_FRAC;

  logic [V_W-1:0] diff;
  logic [P_W-1:0] prod;
  logic [D_W-1:0] drop;
  logic [V_W-1:0] cand;

  always_comb begin
    diff = infl_i - sup_i;
    prod = P_W'(slope_i) * P_W'(diff);
    drop = prod[P_W-1:S_FRAC];
    cand = (drop >= D_W'(max_i)) ? '0 : max_i - V_W'(drop);
    if (sup_i >= infl_i) thr_o = max_i;
    else if (cand < min_i) thr_o = min_i;
    else thr_o = cand;
  end
endmodule

// File: rtl/lim_thr_hdr.sv
module lim_thr_hdr
  import lim_thr_pkg::*;
#(
  parameter int V_W    = 16,
  parameter int H_W    = 5,
  parameter int F_FRAC = 15
) (
  input  logic [V_W-1:0] sup_i,
  input  logic [H_W-1:0] hdr_i,
  output logic [V_W-1:0] thr_o
);
  localparam int F_W   = F_FRAC + 2;
  localparam int N_HDR = 1 << H_W;
  localparam int P_W   = V_W + F_W;
  localparam int R_W   = P_W - F_FRAC;

  logic [F_W-1:0] lut [N_HDR];
  logic [P_W-1:0] prod;
  logic [R_W-1:0] scaled;

  for (genvar g = 0; g < N_HDR; g++) begin : g_lut
    localparam int H = (g >= N_HDR / 2) ? g - N_HDR : g;
    assign lut[g] = F_W'(hdr_factor(H, F_FRAC));
  end

  always_comb begin
    prod   = P_W'(sup_i) * P_W'(lut[hdr_i]);
    scaled = prod[P_W-1:F_FRAC];
    thr_o  = (|scaled[R_W-1:V_W]) ? '1 : scaled[V_W-1:0];
  end
endmodule

// File: rtl/lim_thr_top.sv
module lim_thr_top
  import lim_thr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [V_W-1:0]   sup_i,
  input  logic             sup_vld_i,
  input  logic [V_W-1:0]   max_thr_i,
  input  logic [V_W-1:0]   infl_i,
  input  logic [S_W-1:0]   slope_i,
  input  logic [V_W-1:0]   min_thr_i,
  input  logic [H_W-1:0]   hdr_i,
  input  logic             dyn_mode_i,
  output logic [V_W-1:0]   thr_o,
  output logic             thr_vld_o
);
  logic [V_W-1:0] bp_thr, dyn_thr, thr_q;
  logic           primed_q, vld_q;

  lim_thr_curve #(.V_W(V_W), .S_W(S_W), .S_FRAC(S_FRAC)) i_curve (
    .sup_i  (sup_i),
    .max_i  (max_thr_i),
    .infl_i (infl_i),
    .slope_i(slope_i),
    .min_i  (min_thr_i),
    .thr_o  (bp_thr)
  );

  lim_thr_hdr #(.V_W(V_W), .H_W(H_W), .F_FRAC(F_FRAC)) i_hdr (
    .sup_i(sup_i),
    .hdr_i(hdr_i),
    .thr_o(dyn_thr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thr_q    <= '0;
      primed_q <= 1'b0;
      vld_q    <= 1'b0;
    end else begin
      vld_q <= sup_vld_i;
      if (sup_vld_i) begin
        thr_q    <= dyn_mode_i ? dyn_thr : bp_thr;
        primed_q <= 1'b1;
      end
    end
  end

  // before the first sample, follow the programmed ceiling
  assign thr_o     = primed_q ? thr_q : max_thr_i;
  assign thr_vld_o = vld_q;
endmodule

// File: rtl/lim_thr_chk.sv
module lim_thr_chk
  import lim_thr_pkg::*;
(
  input logic           clk_i,
  input logic           rst_ni,
  input logic [V_W-1:0] sup_i,
  input logic           sup_vld_i,
  input logic [V_W-1:0] max_thr_i,
  input logic [V_W-1:0] infl_i,
  input logic [S_W-1:0] slope_i,
  input logic [V_W-1:0] min_thr_i,
  input logic [H_W-1:0] hdr_i,
  input logic           dyn_mode_i,
  input logic [V_W-1:0] thr_o,
  input logic           thr_vld_o
);
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else if (sup_vld_i) seen_q <= 1'b1;
  end

  a_r2_vld_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sup_vld_i |=> thr_vld_o);
  a_r2_vld_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sup_vld_i |=> !thr_vld_o);
  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && !sup_vld_i) |=> $stable(thr_o));
  a_r4_at_ceiling: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sup_vld_i && !dyn_mode_i && sup_i >= infl_i) |=> thr_o == $past(max_thr_i));
  a_r7_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sup_vld_i && !dyn_mode_i && sup_i < infl_i) |=> thr_o >= $past(min_thr_i));
  a_r8_neg_above: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sup_vld_i && dyn_mode_i && hdr_i[H_W-1]) |=> thr_o >= $past(sup_i));
  a_r8_pos_below: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sup_vld_i && dyn_mode_i && !hdr_i[H_W-1]) |=> thr_o <= $past(sup_i));
endmodule

bind lim_thr_top lim_thr_chk i_chk (.*);

// File: tb/test_lim_thr_top.sv
module test_lim_thr_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] sup_i = '0, max_thr_i = '0, infl_i = '0, min_thr_i = '0;
  logic [15:0] slope_i = '0;
  logic [4:0]  hdr_i = '0;
  logic        sup_vld_i = 1'b0, dyn_mode_i = 1'b1;
  logic [15:0] thr_o;
  logic        thr_vld_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  lim_thr_top i_lim_thr_top (.*);

  function automatic int exp_bp(int s, int mx, int kn, int sl, int mn);
    longint drop;
    int c;
    if (s >= kn) return mx;
    drop = (longint'(sl) * longint'(kn - s)) / 4096;
    c = (drop >= mx) ? 0 : mx - int'(drop);
    return (c < mn) ? mn : c;
  endfunction

  function automatic int exp_dyn(int s, int code);
    int h = (code >= 16) ? code - 32 : code;
    longint f = ((100 - h) * 32768 + 50) / 100;
    longint r = (longint'(s) * f) / 32768;
    return (r > 65535) ? 65535 : int'(r);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive one sample at a negedge; check after the next edge
  task automatic sample(int s, int mx, int kn, int sl, int mn, int hd, bit dm, string req);
    int e = dm ? exp_dyn(s, hd) : exp_bp(s, mx, kn, sl, mn);
    sup_i = 16'(s); max_thr_i = 16'(mx); infl_i = 16'(kn);
    slope_i = 16'(sl); min_thr_i = 16'(mn); hdr_i = 5'(hd); dyn_mode_i = dm;
    sup_vld_i = 1'b1;
    @(negedge clk_i);
    sup_vld_i = 1'b0;
    chk({req, " R2 vld"}, int'(thr_vld_o), 1);
    chk(req, int'(thr_o), e);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int held;
    void'($urandom(32'd4242));
    max_thr_i = 16'h0C00;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 thr", int'(thr_o), 16'h0C00);
    chk("R1 vld", int'(thr_vld_o), 0);
    max_thr_i = 16'h0A80;
    @(negedge clk_i);
    chk("R1 follows ceiling", int'(thr_o), 16'h0A80);

    // directed corners
    sample(16'h0E00, 16'h0C00, 16'h0D00, 16'h1000, 16'h0400, 0, 0, "R4 above knee");
    sample(16'h0D00, 16'h0C00, 16'h0D00, 16'h1000, 16'h0400, 0, 0, "R4 at knee");
    sample(16'h0B00, 16'h0C00, 16'h0D00, 16'h1000, 16'h0400, 0, 0, "R5 slope 1");
    sample(16'h0B00, 16'h0C00, 16'h0D00, 16'h3000, 16'h0000, 0, 0, "R5 slope 3");
    sample(16'h0100, 16'h0C00, 16'h0D00, 16'hFFFF, 16'h0000, 0, 0, "R6 zero clamp");
    chk("R6 zero", int'(thr_o), 0);
    sample(16'h0800, 16'h0C00, 16'h0D00, 16'h2000, 16'h0600, 0, 0, "R7 floor");
    chk("R7 floor value", int'(thr_o), 16'h0600);
    sample(16'h0000, 16'h0C00, 16'h0001, 16'h1000, 16'h0000, 0, 0, "R4 knee low");
    sample(16'h0C00, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16, 1, "R8 hdr -16");
    sample(16'h0C00, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 15, 1, "R8 hdr +15");
    sample(16'h0C00, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 0, 1, "R8 hdr 0");
    chk("R8 unity", int'(thr_o), 16'h0C00);
    sample(16'hFFFF, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16, 1, "R9 saturate");
    chk("R9 max", int'(thr_o), 16'hFFFF);
    sample(16'h0A00, 16'h0100, 16'hFFFF, 16'hFFFF, 16'hF000, 22, 1, "R10 bp inputs ignored");

    // hold: change everything with no strobe
    held = int'(thr_o);
    sup_i = 16'h1234; max_thr_i = 16'h0001; hdr_i = 5'd3; dyn_mode_i = 1'b0;
    min_thr_i = 16'h7777; infl_i = 16'h9999;
    repeat (3) begin
      @(negedge clk_i);
      chk("R3 hold", int'(thr_o), held);
      chk("R2 vld low", int'(thr_vld_o), 0);
    end

    // random sweep
    for (int i = 0; i < 600; i++) begin
      int s  = int'($urandom_range(0, 65535));
      int kn = int'($urandom_range(0, 65535));
      int mx = int'($urandom_range(0, 65535));
      int mn = int'($urandom_range(0, 16'h2000));
      int sl = int'($urandom_range(0, 65535));
      int hd = int'($urandom_range(0, 31));
      bit dm = 1'($urandom_range(0, 1));
      sample(s, mx, kn, sl, mn, hd, dm, dm ? "R8 random" : "R5 R7 random");
      if ($urandom_range(0, 3) == 0) begin
        held = int'(thr_o);
        sup_i = 16'($urandom);
        @(negedge clk_i);
        chk("R3 random hold", int'(thr_o), held);
      end
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule